// File: doc/BRIEF.md
# NAND Hamming ECC corrector

This block judges a 256-byte NAND data chunk from two 24-bit Hamming codes: the one that was written to the spare area and the one recomputed while the chunk was read back. Each code is three bytes, little-endian packed. Bits 10:0 hold the even parities and bits 21:11 hold their complement parities. The syndrome is the XOR of the two codes. From its weight and from a pairing test, the block decides whether the chunk is clean, whether only the code bytes were damaged, whether one data bit can be flipped back, or whether the chunk is lost. For a fixable chunk it reports the byte index and a one-hot mask of the bit to invert. The caller applies that mask to its own buffer.

The two codes arrive on separate valid/ready channels. A pair is taken only when both channels offer a code at once. The result is registered and appears in the cycle after the pair is taken. It is held until the consumer raises `res_ready`. A new pair may be taken in the same cycle as the held result drains.

In wide-page mode a 512-byte page is judged as two 256-byte halves, low half first. The mode is sampled with the first pair of a page. The second result carries the half bit in the byte address and marks the end of the page. A sticky fail flag ORs the damage found in both halves.

The sequencer has four states:
- `S_WAIT_LO` waits for the first pair of a page.
- `S_SHOW_LO` presents a low-half result.
- `S_WAIT_HI` waits for the second pair of a wide page.
- `S_SHOW_HI` presents the high-half result.

Its transitions are:
- take-pair: `S_WAIT_LO`→`S_SHOW_LO`, and `S_WAIT_HI`→`S_SHOW_HI`.
- drain-narrow: `S_SHOW_LO`→`S_WAIT_LO` when the page is narrow.
- drain-to-high: `S_SHOW_LO`→`S_WAIT_HI` when the page is wide.
- drain-end: `S_SHOW_HI`→`S_WAIT_LO`.
- drain-and-take: from a show state straight into the next show state, following the same page rules.

Top module: `nand_ecc_corrector`

## Requirements
- R1: After reset no result is valid, the status is 0, and neither channel is ready until the opposite channel offers a code.
- R2: `stored_ready` is high only when `calc_valid` is high and no result is held back by a low `res_ready`. `calc_ready` follows the same rule with `stored_valid`. A pair is taken only when both channels handshake in the same cycle.
- R3: A taken pair gives `res_valid` in the next cycle. Status, byte and mask stay unchanged while `res_valid` is high and `res_ready` is low.
- R4: Status 0 (clean) is reported when the syndrome is zero, or when either code is all zeros.
- R5: Status 1 (code-field damage) is reported when exactly one of the 24 syndrome bits is set and neither code is zero.
- R6: Status 2 (fixed) is reported when exactly 11 syndrome bits are set and the pairing test holds. For the pairing test, each code has its bits 10:0 XORed with its bits 21:11, the two results are XORed together, and the outcome must be 0x7FF. With status 2, `res_byte[7:0]` is syndrome bits 10:3 and `res_mask` is one-hot at the position given by syndrome bits 2:0.
- R7: Every other syndrome gives status 3 (uncorrectable). This includes 11-bit syndromes that fail the pairing test, and syndromes of any other weight.
- R8: Unless the status is 2, `res_mask` and `res_byte[7:0]` are zero.
- R9: `page_wide` is sampled with the first pair of a page. For a wide page the second result has `res_byte[8]` = 1 and `res_last` = 1, and the first has both at 0. For a narrow page every result has `res_last` = 1 and `res_byte[8]` = 0.
- R10: `res_fail` is high when the current result, or the low-half result of the same wide page, has status 1 or 3.
- R11: When a result drains in the same cycle that both channels are valid, the new pair is taken in that cycle and its result follows without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stored_valid | input | 1 | Stored code offered |
| stored_ready | output | 1 | Stored code taken this cycle if valid |
| stored_code | input | 24 | Code read from the spare area |
| calc_valid | input | 1 | Recomputed code offered |
| calc_ready | output | 1 | Recomputed code taken this cycle if valid |
| calc_code | input | 24 | Code computed over the read data |
| page_wide | input | 1 | 1 = 512-byte page judged as two halves |
| res_valid | output | 1 | Result held |
| res_ready | input | 1 | Consumer takes the result |
| res_status | output | 2 | 0 clean, 1 code damage, 2 fixed, 3 uncorrectable |
| res_byte | output | 9 | Bit 8 half, bits 7:0 failing byte |
| res_mask | output | 8 | One-hot bit to invert |
| res_last | output | 1 | Result closes the page |
| res_fail | output | 1 | Page damage seen so far |

## Verification
Two functions can land in one cycle: the drain of a held result and the taking of a new pair. In a wide page, that coincidence also moves the sequencer from the low half straight into the high half. The bench provokes this by holding both channels valid back to back while `res_ready` is either held high or toggled at random. A behavioural model then predicts, on every clock, the readiness of both channels and the contents of the next result. This shows whether the drained result was lost, repeated or merged with the next one, and whether the half bit and the page fail flag followed the page correctly.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ECC_CLEAN    = 2'd0,
        ECC_CODE_HIT = 2'd1,
        ECC_FIXED    = 2'd2,
        ECC_FATAL    = 2'd3
    } ecc_status_e;

    typedef enum logic [1:0] {
        S_WAIT_LO = 2'd0,
        S_SHOW_LO = 2'd1,
        S_WAIT_HI = 2'd2,
        S_SHOW_HI = 2'd3
    } seq_state_e;

endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
    parameter  int W  = 24,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    logic [CW-1:0] run [W+1];

    assign run[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_acc
        assign run[i+1] = run[i] + CW'(vec[i]);
    end

    assign count = run[W];

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
    import nand_ecc_pkg::*;
#(
    parameter  int CODE_W = 24,
    parameter  int FIELD_W = 11,
    parameter  int BIT_W = 3,
    localparam int BYTE_W = FIELD_W - BIT_W,
    localparam int MASK_W = 1 << BIT_W,
    localparam int CW = $clog2(CODE_W + 1)
) (
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    output ecc_status_e       status,
    output logic [BYTE_W-1:0] byte_idx,
    output logic [MASK_W-1:0] flip_mask,
    output logic              hard_fail
);

    logic [CODE_W-1:0]  syndrome;
    logic [CW-1:0]      weight;
    logic [FIELD_W-1:0] fold_stored;
    logic [FIELD_W-1:0] fold_calc;
    logic               pair_ok;
    logic               any_blank;

    assign syndrome = stored_code ^ calc_code;

    ecc_popcount #(.W(CODE_W)) u_weight (
        .vec   (syndrome),
        .count (weight)
    );

    // Parity and complement parity halves folded per code
    assign fold_stored = stored_code[FIELD_W-1:0] ^ stored_code[2*FIELD_W-1:FIELD_W];
    assign fold_calc   = calc_code[FIELD_W-1:0]   ^ calc_code[2*FIELD_W-1:FIELD_W];
    assign pair_ok     = &(fold_stored ^ fold_calc);

    assign any_blank = (syndrome == '0) || (stored_code == '0) || (calc_code == '0);

    always_comb begin
        if (any_blank) begin
            status = ECC_CLEAN;
        end else if (weight == CW'(1)) begin
            status = ECC_CODE_HIT;
        end else if ((weight == CW'(FIELD_W)) && pair_ok) begin
            status = ECC_FIXED;
        end else begin
            status = ECC_FATAL;
        end
    end

    assign byte_idx  = (status == ECC_FIXED) ? syndrome[FIELD_W-1:BIT_W] : '0;
    assign hard_fail = (status == ECC_CODE_HIT) || (status == ECC_FATAL);

    for (genvar j = 0; j < MASK_W; j++) begin : g_mask
        assign flip_mask[j] = (status == ECC_FIXED) && (syndrome[BIT_W-1:0] == BIT_W'(j));
    end

endmodule

// File: rtl/ecc_page_seq.sv
module ecc_page_seq
    import nand_ecc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pair_valid,
    input  logic res_ready,
    input  logic page_wide,
    output logic open_slot,
    output logic accept,
    output logic into_hi,
    output logic res_valid,
    output logic res_last
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       wide_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_WAIT_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Page width captured with the first pair of a page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
        end else if (accept && !into_hi) begin
            wide_q <= page_wide;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT_LO: if (accept) state_d = S_SHOW_LO;
            S_WAIT_HI: if (accept) state_d = S_SHOW_HI;
            S_SHOW_LO: begin
                if (accept) begin
                    state_d = wide_q ? S_SHOW_HI : S_SHOW_LO;
                end else if (res_ready) begin
                    state_d = wide_q ? S_WAIT_HI : S_WAIT_LO;
                end
            end
            S_SHOW_HI: begin
                if (accept) begin
                    state_d = S_SHOW_LO;
                end else if (res_ready) begin
                    state_d = S_WAIT_LO;
                end
            end
            default: state_d = S_WAIT_LO;
        endcase
    end

    // Outputs
    always_comb begin
        res_valid = (state_q == S_SHOW_LO) || (state_q == S_SHOW_HI);
        open_slot = !res_valid || res_ready;
        accept    = pair_valid && open_slot;
        into_hi   = (state_q == S_WAIT_HI) || ((state_q == S_SHOW_LO) && wide_q);
        res_last  = (state_q == S_SHOW_HI) || ((state_q == S_SHOW_LO) && !wide_q);
    end

    AST_WAIT_HI_ONLY_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_HI) |-> wide_q);  // R9

endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
    import nand_ecc_pkg::*;
#(
    parameter  int CODE_W = 24,
    parameter  int FIELD_W = 11,
    parameter  int BIT_W = 3,
    localparam int BYTE_W = FIELD_W - BIT_W,
    localparam int MASK_W = 1 << BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stored_valid,
    output logic              stored_ready,
    input  logic [CODE_W-1:0] stored_code,
    input  logic              calc_valid,
    output logic              calc_ready,
    input  logic [CODE_W-1:0] calc_code,
    input  logic              page_wide,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [1:0]        res_status,
    output logic [BYTE_W:0]   res_byte,
    output logic [MASK_W-1:0] res_mask,
    output logic              res_last,
    output logic              res_fail
);

    ecc_status_e       cls_status;
    logic [BYTE_W-1:0] cls_byte;
    logic [MASK_W-1:0] cls_mask;
    logic              cls_fail;
    logic              open_slot;
    logic              accept;
    logic              into_hi;

    ecc_classify #(
        .CODE_W  (CODE_W),
        .FIELD_W (FIELD_W),
        .BIT_W   (BIT_W)
    ) u_classify (
        .stored_code (stored_code),
        .calc_code   (calc_code),
        .status      (cls_status),
        .byte_idx    (cls_byte),
        .flip_mask   (cls_mask),
        .hard_fail   (cls_fail)
    );

    ecc_page_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_valid (stored_valid && calc_valid),
        .res_ready  (res_ready),
        .page_wide  (page_wide),
        .open_slot  (open_slot),
        .accept     (accept),
        .into_hi    (into_hi),
        .res_valid  (res_valid),
        .res_last   (res_last)
    );

    assign stored_ready = calc_valid && open_slot;
    assign calc_ready   = stored_valid && open_slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_status <= ECC_CLEAN;
            res_byte   <= '0;
            res_mask   <= '0;
            res_fail   <= 1'b0;
        end else if (accept) begin
            res_status <= cls_status;
            res_byte   <= {into_hi, cls_byte};
            res_mask   <= cls_mask;
            res_fail   <= into_hi ? (res_fail || cls_fail) : cls_fail;
        end
    end

    AST_NO_TAKE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |-> (!stored_ready && !calc_ready));  // R2

    AST_READY_NEEDS_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
        stored_ready |-> calc_valid);  // R2

    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (stored_valid && stored_ready) |=> res_valid);  // R3

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_status) &&
                                       $stable(res_byte) && $stable(res_mask)));  // R3

    AST_MASK_ONEHOT_ON_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'd2) |-> ($countones(res_mask) == 1));  // R6

    AST_QUIET_UNLESS_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status != 2'd2) |-> (res_mask == '0 && res_byte[BYTE_W-1:0] == '0));  // R8

    AST_HIGH_HALF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_byte[BYTE_W]) |-> res_last);  // R9

    AST_FAIL_COVERS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_status == 2'd1 || res_status == 2'd3)) |-> res_fail);  // R10

endmodule

// File: tb/nand_ecc_corrector_test.sv
module nand_ecc_corrector_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stored_valid = 1'b0;
    logic        stored_ready;
    logic [23:0] stored_code = '0;
    logic        calc_valid = 1'b0;
    logic        calc_ready;
    logic [23:0] calc_code = '0;
    logic        page_wide = 1'b0;
    logic        res_valid;
    logic        res_ready = 1'b1;
    logic [1:0]  res_status;
    logic [8:0]  res_byte;
    logic [7:0]  res_mask;
    logic        res_last;
    logic        res_fail;

    int n_chk = 0;
    int n_fail = 0;
    int rr_mode = 0;
    bit done = 0;

    // Reference model state
    bit exp_valid = 0;
    int exp_stat = 0;
    int exp_byte = 0;
    int exp_mask = 0;
    bit exp_last = 0;
    bit exp_fail = 0;
    bit m_half = 0;
    bit m_wide = 0;
    bit m_pend_hi = 0;

    always #5 clk = ~clk;

    nand_ecc_corrector uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .stored_valid (stored_valid),
        .stored_ready (stored_ready),
        .stored_code  (stored_code),
        .calc_valid   (calc_valid),
        .calc_ready   (calc_ready),
        .calc_code    (calc_code),
        .page_wide    (page_wide),
        .res_valid    (res_valid),
        .res_ready    (res_ready),
        .res_status   (res_status),
        .res_byte     (res_byte),
        .res_mask     (res_mask),
        .res_last     (res_last),
        .res_fail     (res_fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void ref_cls(input logic [23:0] s, input logic [23:0] c,
                                    output int st, output int idx, output int bitn);
        logic [23:0] x = s ^ c;
        int w = $countones(x);
        int fs = (int'(s) & 'h7FF) ^ ((int'(s) >> 11) & 'h7FF);
        int fc = (int'(c) & 'h7FF) ^ ((int'(c) >> 11) & 'h7FF);
        if (x == 0 || s == 0 || c == 0) st = 0;
        else if (w == 1) st = 1;
        else if (w == 11 && (fs ^ fc) == 2047) st = 2;
        else st = 3;
        idx  = (int'(x) >> 3) & 255;
        bitn = int'(x) & 7;
    endfunction

    function automatic string stat_tag(input int st);
        case (st)
            0: return "R4 status";
            1: return "R5 status";
            2: return "R6 status";
            default: return "R7 status";
        endcase
    endfunction

    // Cycle-by-cycle comparison and model update, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit open_s;
            bit acc;
            chk("R3 res_valid", int'(res_valid), int'(exp_valid));
            if (exp_valid) begin
                chk(stat_tag(exp_stat), int'(res_status), exp_stat);
                chk(exp_stat == 2 ? "R6 mask" : "R8 mask", int'(res_mask), exp_mask);
                chk(exp_stat == 2 ? "R6 byte" : "R8 byte", int'(res_byte[7:0]), exp_byte & 255);
                chk("R9 half bit", int'(res_byte[8]), exp_byte >> 8);
                chk("R9 res_last", int'(res_last), int'(exp_last));
                chk("R10 res_fail", int'(res_fail), int'(exp_fail));
            end
            open_s = !exp_valid || res_ready;
            chk((exp_valid && res_ready) ? "R11 stored_ready" : "R2 stored_ready",
                int'(stored_ready), int'(calc_valid && open_s));
            chk((exp_valid && res_ready) ? "R11 calc_ready" : "R2 calc_ready",
                int'(calc_ready), int'(stored_valid && open_s));
            acc = stored_valid && calc_valid && open_s;
            if (acc) begin
                int st, idx, bn;
                bit hi;
                bit f;
                ref_cls(stored_code, calc_code, st, idx, bn);
                hi = exp_valid ? (!m_half && m_wide) : m_pend_hi;
                f = (st == 1 || st == 3);
                exp_stat = st;
                exp_mask = (st == 2) ? (1 << bn) : 0;
                if (hi) begin
                    m_half   = 1;
                    exp_fail = exp_fail | f;
                    exp_last = 1;
                end else begin
                    m_half   = 0;
                    m_wide   = page_wide;
                    exp_fail = f;
                    exp_last = !page_wide;
                end
                exp_byte  = (int'(m_half) << 8) | ((st == 2) ? idx : 0);
                exp_valid = 1;
                m_pend_hi = 0;
            end else if (exp_valid && res_ready) begin
                m_pend_hi = !m_half && m_wide;
                exp_valid = 0;
            end
        end
    end

    // Consumer ready driver
    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (rr_mode)
                0: res_ready = 1'b1;
                1: res_ready = ($urandom % 3) != 0;
                default: res_ready = 1'b0;
            endcase
        end
    end

    // Offer a pair; leaves the valids high, caller decides on idle
    task automatic send(input logic [23:0] s, input logic [23:0] c, input bit wide, input int skew);
        stored_code  = s;
        calc_code    = c;
        page_wide    = wide;
        stored_valid = 1'b1;
        calc_valid   = (skew == 0);
        repeat (skew) begin
            @(posedge clk);
            #1;
        end
        calc_valid = 1'b1;
        do @(negedge clk); while (!(stored_ready && calc_ready));
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        stored_valid = 1'b0;
        calc_valid   = 1'b0;
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [23:0] fix_code(input logic [23:0] s, input logic [10:0] a);
        return s ^ {2'b00, ~a, a};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 res_status", int'(res_status), 0);
        chk("R1 stored_ready", int'(stored_ready), 0);
        chk("R1 calc_ready", int'(calc_ready), 0);
        @(posedge clk);
        #1;

        // Narrow pages, directed classes
        send(24'h123456, 24'h123456, 0, 0);            // R4 equal
        send(24'h000000, 24'h00F00F, 0, 1);            // R4 stored blank
        send(24'h3A5A5A, 24'h000000, 0, 2);            // R4 calc blank
        send(24'h3A5A5A, 24'hBA5A5A, 0, 0);            // R5 bit 23
        send(24'h3A5A5A, 24'h3A5A5B, 0, 0);            // R5 bit 0
        send(24'h0ABCDE, fix_code(24'h0ABCDE, 11'h000), 0, 0);  // R6 byte 0 bit 0
        send(24'h0ABCDE, fix_code(24'h0ABCDE, 11'h7FF), 0, 0);  // R6 byte 255 bit 7
        send(24'h155555, fix_code(24'h155555, 11'h2A5), 0, 0);  // R6 mid
        send(24'h0ABCDE, 24'h0ABCDE ^ 24'hC001FF, 0, 0);        // R7 weight 11, pair test fails
        send(24'h0ABCDE, 24'h0ABCDE ^ 24'h000081, 0, 0);        // R7 two bits
        idle(3);

        // Wide pages (R9, R10), with the mode input flipped mid-page
        send(24'h0ABCDE, fix_code(24'h0ABCDE, 11'h155), 1, 0);
        send(24'h111111, 24'h111111, 0, 0);
        send(24'h222222, 24'h222223, 1, 0);
        send(24'h333333, 24'h333333, 1, 1);
        idle(2);
        send(24'h444444, 24'h444444, 1, 0);
        idle(2);
        send(24'h444444, 24'h444444 ^ 24'h00000F, 0, 0);
        idle(3);

        // Random traffic with back-to-back pairs and consumer stalls (R11)
        for (int k = 0; k < 600; k++) begin
            int kind = $urandom % 6;
            logic [23:0] s = 24'($urandom) | 24'h1;
            logic [23:0] c;
            case (kind)
                0: c = s;
                1: begin s = '0; c = 24'($urandom); end
                2: c = s ^ (24'h1 << ($urandom % 24));
                3: c = fix_code(s, 11'($urandom));
                4: c = s ^ (24'h3 << ($urandom % 22));
                default: c = 24'($urandom);
            endcase
            if (k % 100 == 0) rr_mode = (k / 100) % 2;
            send(s, c, ($urandom % 2) == 1, ((k % 7) == 0) ? int'($urandom % 3) : 0);
            if ((k % 13) == 0) idle(1);
        end
        rr_mode = 0;
        idle(6);
        finish_run();
    end

endmodule